// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Decoder

This block sits beside one processor's local interrupt unit and turns 64-bit interrupt-command writes into actions on the other processors. A command is written as two 32-bit halves in legacy addressing mode, or as one 64-bit word in extended addressing mode. Fixed-vector and non-maskable commands become one-cycle per-CPU delivery strobes. The targets are chosen by a two-bit shorthand: the physical destination index, the sender itself, every active CPU, or every active CPU except the sender.

The block also tracks the boot progress of every CPU with a three-state machine: held in reset-wait, waiting for a startup message, or running. An asserted INIT moves a held CPU to the waiting state. A startup message then releases it, adds it to the active set and emits a start pulse with the CPU index and the start address. Only CPU 0 may drive this sequence, and only towards CPUs other than itself. Commands that the block cannot act on raise a one-cycle unhandled strobe, so that a slower agent can take them over.

Top module: `ipi_cmd_decoder`

## Requirements
- R1: Command fields: vector in bits 7:0, delivery mode in bits 10:8 (000 fixed, 100 NMI, 101 INIT, 110 startup), INIT level in bit 14 (1 = asserted), shorthand in bits 19:18. The destination is bits 63:56 in legacy mode and bits 63:32 in extended mode.
- R2: In legacy mode a high-half write only stores bits 31:0 and produces no output. A low-half write sends the command formed from that stored high half and bits 31:0 of the write data.
- R3: In extended mode a high-half write is ignored and leaves the stored high half unchanged. A low-half write sends all 64 bits of the write data.
- R4: Fixed commands assert `fixedStrobe` for the selected targets and present the vector on `fixedVector`. Shorthand 00 selects the destination CPU (none if it is out of range), 01 the sender, 10 all active CPUs, 11 all active CPUs except the sender.
- R5: NMI commands use the same target selection on `nmiStrobe` and never assert `fixedStrobe` in the same cycle.
- R6: After reset CPU 0 is running (code 2) and every other CPU is held (code 0). The started set is empty, so `activeOut` equals `activeIn`.
- R7: An INIT with the level bit clear changes no boot state and raises no unhandled strobe.
- R8: An asserted INIT from CPU 0 to a destination in 1..NCPU-1 moves that CPU from held (0) to waiting (1). A CPU in any other state keeps its state.
- R9: An INIT or startup command from a sender other than CPU 0, or to destination 0, or to a destination of NCPU or more, raises `unhandled` and changes no boot state.
- R10: A valid startup to a waiting CPU sets it running (2), adds it to `activeOut` for good, and pulses `startPulse` with `startCpu` = destination and `startAddr` = vector << 12. A startup to a CPU that is not waiting produces no pulse and no unhandled strobe.
- R11: Delivery modes other than fixed, NMI, INIT and startup raise `unhandled` and deliver nothing.
- R12: All strobes and pulses appear in the cycle after the write edge and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| x2Mode | input | 1 | 1 = extended addressing, 0 = legacy |
| selfId | input | IDW | Index of the sending CPU |
| activeIn | input | NCPU | CPUs active by external means |
| wrLo | input | 1 | Write to low command half (send) |
| wrHi | input | 1 | Write to high command half |
| wrData | input | 64 | Write data |
| fixedStrobe | output | NCPU | Per-CPU fixed-interrupt delivery strobe |
| fixedVector | output | 8 | Vector accompanying fixedStrobe |
| nmiStrobe | output | NCPU | Per-CPU NMI delivery strobe |
| startPulse | output | 1 | A CPU was started |
| startCpu | output | IDW | Index of the started CPU |
| startAddr | output | 20 | Start address (vector << 12) |
| unhandled | output | 1 | Command not handled by this block |
| activeOut | output | NCPU | activeIn OR CPUs started here |
| bootState | output | 2*NCPU | Boot code per CPU, 2 bits each, CPU i at bits 2i+1:2i |

## Verification
The embedded properties check the invariants of the boot machines on every cycle. A running CPU never leaves that state, and a waiting CPU never goes back to held. CPU 0 stays running, the started set only grows, and each start pulse names a CPU that is now running and active. They also check that the fixed and NMI strobes are never raised together and that an extended-mode high write leaves the stored half alone. Only the directed scenarios can show the other behaviours: the destination bit positions in each mode, the four shorthand target sets, the sender and range checks that divert a command to the unhandled strobe, the ignored deasserted INIT, and the start address value.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    BOOT_HELD = 2'd0,
    BOOT_WAIT = 2'd1,
    BOOT_RUN  = 2'd2
  } bootState_e;

  localparam logic [2:0] DM_FIXED = 3'b000;
  localparam logic [2:0] DM_NMI   = 3'b100;
  localparam logic [2:0] DM_INIT  = 3'b101;
  localparam logic [2:0] DM_START = 3'b110;

  localparam logic [1:0] SH_DEST    = 2'b00;
  localparam logic [1:0] SH_SELF    = 2'b01;
  localparam logic [1:0] SH_ALL     = 2'b10;
  localparam logic [1:0] SH_OTHERS  = 2'b11;

  // Decoded fields of one command word
  typedef struct packed {
    logic [7:0]  vector;
    logic [2:0]  mode;
    logic        levelHi;
    logic [1:0]  shorthand;
    logic [31:0] dest;
  } cmdFields_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic fireFixed;
    logic fireNmi;
    logic fireStart;
  } dpStrobe_t;

endpackage

// File: rtl/ipi_dp.sv
module ipi_dp
  import ipi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int IDW  = $clog2(NCPU)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             x2Mode,
  input  logic [IDW-1:0]   selfId,
  input  logic [NCPU-1:0]  activeAll,
  input  logic             wrLo,
  input  logic             wrHi,
  input  logic [63:0]      wrData,
  input  dpStrobe_t        strobe,
  output cmdFields_t       fields,
  output logic             sendValid,
  output logic [NCPU-1:0]  fixedQ,
  output logic [7:0]       vectorQ,
  output logic [NCPU-1:0]  nmiQ,
  output logic [19:0]      startAddrQ,
  output logic [IDW-1:0]   startCpuQ
);

  logic [31:0]     hiQ;
  logic [63:0]     cmdWord;
  logic [NCPU-1:0] destHit;
  logic [NCPU-1:0] selfHit;
  logic [NCPU-1:0] targets;

  // High half is only stored in legacy mode
  always_ff @(posedge clk) begin
    if (!rstN)                hiQ <= '0;
    else if (wrHi && !x2Mode) hiQ <= wrData[31:0];
  end

  assign cmdWord   = x2Mode ? wrData : {hiQ, wrData[31:0]};
  assign sendValid = wrLo;

  always_comb begin
    fields.vector    = cmdWord[7:0];
    fields.mode      = cmdWord[10:8];
    fields.levelHi   = cmdWord[14];
    fields.shorthand = cmdWord[19:18];
    fields.dest      = x2Mode ? cmdWord[63:32] : {24'd0, cmdWord[63:56]};
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_hit
    assign destHit[i] = (fields.dest == 32'(i));
    assign selfHit[i] = (selfId == IDW'(i));
  end

  always_comb begin
    unique case (fields.shorthand)
      SH_DEST:   targets = destHit;
      SH_SELF:   targets = selfHit;
      SH_ALL:    targets = activeAll;
      default:   targets = activeAll & ~selfHit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fixedQ     <= '0;
      nmiQ       <= '0;
      vectorQ    <= '0;
      startAddrQ <= '0;
      startCpuQ  <= '0;
    end else begin
      fixedQ <= strobe.fireFixed ? targets : '0;
      nmiQ   <= strobe.fireNmi   ? targets : '0;
      if (strobe.fireFixed) vectorQ <= fields.vector;
      if (strobe.fireStart) begin
        startAddrQ <= {fields.vector, 12'h000};
        startCpuQ  <= fields.dest[IDW-1:0];
      end
    end
  end

  p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && x2Mode) |=> $stable(hiQ));

  p_fix_nmi_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|fixedQ) |-> (nmiQ == '0));

endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int IDW  = $clog2(NCPU)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDW-1:0]    selfId,
  input  cmdFields_t        fields,
  input  logic              sendValid,
  output dpStrobe_t         strobe,
  output logic              unhandledQ,
  output logic              startPulseQ,
  output logic [NCPU-1:0]   startedQ,
  output logic [2*NCPU-1:0] bootFlat
);

  bootState_e      bootQ [NCPU];
  logic [IDW-1:0]  tgt;
  logic [IDW-1:0]  startTgtQ;
  logic            senderOk;
  logic            destOk;
  logic            initGo;
  logic            unhandledD;

  assign tgt      = fields.dest[IDW-1:0];
  assign senderOk = (selfId == '0);
  assign destOk   = (fields.dest != 32'd0) && (fields.dest < 32'(NCPU));

  always_comb begin
    strobe     = '0;
    initGo     = 1'b0;
    unhandledD = 1'b0;
    if (sendValid) begin
      case (fields.mode)
        DM_FIXED: strobe.fireFixed = 1'b1;
        DM_NMI:   strobe.fireNmi   = 1'b1;
        DM_INIT: begin
          if (fields.levelHi) begin
            if (senderOk && destOk) initGo = (bootQ[tgt] == BOOT_HELD);
            else                    unhandledD = 1'b1;
          end
        end
        DM_START: begin
          if (senderOk && destOk) strobe.fireStart = (bootQ[tgt] == BOOT_WAIT);
          else                    unhandledD = 1'b1;
        end
        default: unhandledD = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NCPU; i++) bootQ[i] <= (i == 0) ? BOOT_RUN : BOOT_HELD;
      startedQ    <= '0;
      unhandledQ  <= 1'b0;
      startPulseQ <= 1'b0;
      startTgtQ   <= '0;
    end else begin
      unhandledQ  <= unhandledD;
      startPulseQ <= strobe.fireStart;
      if (initGo) bootQ[tgt] <= BOOT_WAIT;
      if (strobe.fireStart) begin
        bootQ[tgt]    <= BOOT_RUN;
        startedQ[tgt] <= 1'b1;
        startTgtQ     <= tgt;
      end
    end
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_flat
    assign bootFlat[2*i +: 2] = bootQ[i];

    p_run_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
      (bootQ[i] == BOOT_RUN) |=> (bootQ[i] == BOOT_RUN));

    p_wait_fwd_r8: assert property (@(posedge clk) disable iff (!rstN)
      (bootQ[i] == BOOT_WAIT) |=> (bootQ[i] != BOOT_HELD));
  end

  p_cpu0_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    bootQ[0] == BOOT_RUN);

  p_start_marks_r10: assert property (@(posedge clk) disable iff (!rstN)
    startPulseQ |-> (bootQ[startTgtQ] == BOOT_RUN && startedQ[startTgtQ]));

  p_started_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((startedQ & $past(startedQ)) == $past(startedQ)));

  p_unh_not_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    unhandledQ |-> !startPulseQ);

endmodule

// File: rtl/ipi_cmd_decoder.sv
module ipi_cmd_decoder
  import ipi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int IDW  = $clog2(NCPU)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              x2Mode,
  input  logic [IDW-1:0]    selfId,
  input  logic [NCPU-1:0]   activeIn,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [63:0]       wrData,
  output logic [NCPU-1:0]   fixedStrobe,
  output logic [7:0]        fixedVector,
  output logic [NCPU-1:0]   nmiStrobe,
  output logic              startPulse,
  output logic [IDW-1:0]    startCpu,
  output logic [19:0]       startAddr,
  output logic              unhandled,
  output logic [NCPU-1:0]   activeOut,
  output logic [2*NCPU-1:0] bootState
);

  cmdFields_t      fields;
  dpStrobe_t       strobe;
  logic            sendValid;
  logic [NCPU-1:0] startedQ;

  assign activeOut = activeIn | startedQ;

  ipi_dp #(.NCPU(NCPU), .IDW(IDW)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .x2Mode    (x2Mode),
    .selfId    (selfId),
    .activeAll (activeOut),
    .wrLo      (wrLo),
    .wrHi      (wrHi),
    .wrData    (wrData),
    .strobe    (strobe),
    .fields    (fields),
    .sendValid (sendValid),
    .fixedQ    (fixedStrobe),
    .vectorQ   (fixedVector),
    .nmiQ      (nmiStrobe),
    .startAddrQ(startAddr),
    .startCpuQ (startCpu)
  );

  ipi_ctrl #(.NCPU(NCPU), .IDW(IDW)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .selfId     (selfId),
    .fields     (fields),
    .sendValid  (sendValid),
    .strobe     (strobe),
    .unhandledQ (unhandled),
    .startPulseQ(startPulse),
    .startedQ   (startedQ),
    .bootFlat   (bootState)
  );

endmodule

// File: tb/test_ipi_cmd_decoder.sv
module test_ipi_cmd_decoder;

  localparam int NCPU = 8;
  localparam int IDW  = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              x2Mode = 1'b0;
  logic [IDW-1:0]    selfId = '0;
  logic [NCPU-1:0]   activeIn = 8'h03;
  logic              wrLo = 1'b0;
  logic              wrHi = 1'b0;
  logic [63:0]       wrData = '0;
  logic [NCPU-1:0]   fixedStrobe;
  logic [7:0]        fixedVector;
  logic [NCPU-1:0]   nmiStrobe;
  logic              startPulse;
  logic [IDW-1:0]    startCpu;
  logic [19:0]       startAddr;
  logic              unhandled;
  logic [NCPU-1:0]   activeOut;
  logic [2*NCPU-1:0] bootState;

  int runCnt  = 0;
  int failCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ipi_cmd_decoder #(.NCPU(NCPU), .IDW(IDW)) i_ipi_cmd_decoder (
    .clk(clk), .rstN(rstN), .x2Mode(x2Mode), .selfId(selfId), .activeIn(activeIn),
    .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData),
    .fixedStrobe(fixedStrobe), .fixedVector(fixedVector), .nmiStrobe(nmiStrobe),
    .startPulse(startPulse), .startCpu(startCpu), .startAddr(startAddr),
    .unhandled(unhandled), .activeOut(activeOut), .bootState(bootState)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    runCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mkLo(input logic [1:0] sh, input logic lvl,
                                       input logic [2:0] mode, input logic [7:0] vec);
    return {12'd0, sh, 3'd0, lvl, 3'd0, mode, vec};
  endfunction

  // Drive a write; outputs are sampled 1 ns after the capturing edge
  task automatic writeLo(input logic [63:0] d);
    @(negedge clk);
    wrData = d; wrLo = 1'b1;
    @(posedge clk); #1;
    wrLo = 1'b0;
  endtask

  task automatic writeHi(input logic [31:0] d);
    @(negedge clk);
    wrData = {32'd0, d}; wrHi = 1'b1;
    @(posedge clk); #1;
    wrHi = 1'b0;
  endtask

  task automatic legacySend(input logic [7:0] dest, input logic [31:0] lo);
    writeHi({dest, 24'd0});
    writeLo({32'd0, lo});
  endtask

  task automatic t_reset;
    chk("R6 boot codes after reset", bootState, 16'h0002);
    chk("R6 activeOut after reset", activeOut, 8'h03);
    chk("R12 no strobes after reset", {fixedStrobe, nmiStrobe, startPulse, unhandled}, 0);
  endtask

  task automatic t_legacy;
    x2Mode = 1'b0; selfId = 3'd0;
    writeHi(32'h0500_0000);
    chk("R2 high write produces nothing", {fixedStrobe, nmiStrobe, startPulse, unhandled}, 0);
    writeLo({32'hFFFF_FFFF, mkLo(2'b00, 1'b0, 3'b000, 8'h41)});
    chk("R2 legacy send uses stored high dest 5", fixedStrobe, 8'h20);
    chk("R1 vector from bits 7:0", fixedVector, 8'h41);
    @(posedge clk); #1;
    chk("R12 strobe lasts one cycle", fixedStrobe, 8'h00);
  endtask

  task automatic t_extended;
    x2Mode = 1'b1;
    writeHi(32'h0700_0000);
    writeLo({32'd6, mkLo(2'b00, 1'b0, 3'b000, 8'h52)});
    chk("R1 extended dest from bits 63:32", fixedStrobe, 8'h40);
    writeLo({32'h0000_0106, mkLo(2'b00, 1'b0, 3'b000, 8'h52)});
    chk("R4 out-of-range dest delivers nothing", fixedStrobe, 8'h00);
    x2Mode = 1'b0;
    writeLo({32'd0, mkLo(2'b00, 1'b0, 3'b000, 8'h53)});
    chk("R3 extended high write ignored, dest still 5", fixedStrobe, 8'h20);
  endtask

  task automatic t_shorthand;
    selfId = 3'd2;
    writeLo({32'd0, mkLo(2'b01, 1'b0, 3'b000, 8'h60)});
    chk("R4 shorthand self", fixedStrobe, 8'h04);
    writeLo({32'd0, mkLo(2'b10, 1'b0, 3'b000, 8'h61)});
    chk("R4 shorthand all active", fixedStrobe, 8'h03);
    selfId = 3'd1;
    writeLo({32'd0, mkLo(2'b11, 1'b0, 3'b000, 8'h62)});
    chk("R4 shorthand all but self", fixedStrobe, 8'h01);
    writeLo({32'd0, mkLo(2'b10, 1'b0, 3'b100, 8'h00)});
    chk("R5 NMI to all active", nmiStrobe, 8'h03);
    chk("R5 NMI raises no fixed strobe", fixedStrobe, 8'h00);
    selfId = 3'd0;
  endtask

  task automatic t_init;
    legacySend(8'd3, mkLo(2'b00, 1'b0, 3'b101, 8'h00));
    chk("R7 deasserted INIT leaves state", bootState, 16'h0002);
    chk("R7 deasserted INIT not unhandled", unhandled, 1'b0);
    legacySend(8'd3, mkLo(2'b00, 1'b1, 3'b101, 8'h00));
    chk("R8 INIT moves CPU3 to wait", bootState, 16'h0042);
    chk("R8 valid INIT not unhandled", unhandled, 1'b0);
  endtask

  task automatic t_rejects;
    selfId = 3'd1;
    legacySend(8'd4, mkLo(2'b00, 1'b1, 3'b101, 8'h00));
    chk("R9 INIT from non-zero sender unhandled", unhandled, 1'b1);
    chk("R9 rejected INIT leaves state", bootState, 16'h0042);
    @(posedge clk); #1;
    chk("R12 unhandled lasts one cycle", unhandled, 1'b0);
    selfId = 3'd0;
    legacySend(8'd0, mkLo(2'b00, 1'b0, 3'b110, 8'h10));
    chk("R9 startup to CPU0 unhandled", unhandled, 1'b1);
    legacySend(8'd8, mkLo(2'b00, 1'b1, 3'b101, 8'h00));
    chk("R9 INIT to dest >= NCPU unhandled", unhandled, 1'b1);
    legacySend(8'd3, mkLo(2'b00, 1'b0, 3'b010, 8'h33));
    chk("R11 unsupported mode unhandled", unhandled, 1'b1);
    chk("R11 unsupported mode delivers nothing", {fixedStrobe, nmiStrobe, startPulse}, 0);
    chk("R9 R11 rejects leave state", bootState, 16'h0042);
  endtask

  task automatic t_start;
    legacySend(8'd4, mkLo(2'b00, 1'b0, 3'b110, 8'h20));
    chk("R10 startup to held CPU ignored", {startPulse, unhandled}, 0);
    legacySend(8'd3, mkLo(2'b00, 1'b0, 3'b110, 8'h9A));
    chk("R10 start pulse", startPulse, 1'b1);
    chk("R10 start cpu", startCpu, 3'd3);
    chk("R10 start address", startAddr, 20'h9A000);
    chk("R10 CPU3 running", bootState, 16'h0082);
    chk("R10 CPU3 active", activeOut, 8'h0B);
    @(posedge clk); #1;
    chk("R12 start pulse lasts one cycle", startPulse, 1'b0);
    legacySend(8'd3, mkLo(2'b00, 1'b1, 3'b101, 8'h00));
    chk("R8 INIT to running CPU keeps state", bootState, 16'h0082);
    legacySend(8'd3, mkLo(2'b00, 1'b0, 3'b110, 8'h9A));
    chk("R10 repeated startup gives no pulse", {startPulse, unhandled}, 0);
    writeLo({32'd0, mkLo(2'b10, 1'b0, 3'b000, 8'h70)});
    chk("R4 R10 started CPU joins all-active set", fixedStrobe, 8'h0B);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_legacy();
    t_extended();
    t_shorthand();
    t_init();
    t_rejects();
    t_start();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      runCnt++;
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

endmodule